// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block sits next to a processor core's exception logic. It works out which interrupt dispatch mode is active from five control fields. Those fields are a boot-vector select, an interrupt-vector select, a vector spacing code, a vectored-capable flag and an external-controller flag.

It builds eight pending lines: two software lines and six hardware lines. A timer request and a performance-counter request can each be steered onto a hardware line. The pending lines are masked with per-line enable bits and qualified by the global enable, exception-level and error-level state. The highest-priority request wins.

On a new qualified request the block registers a one-cycle taken strobe. With the strobe it latches a 3-bit vector number and the handler byte offset from the exception base. The current pending lines are visible at all times, so software can inspect them whether or not an interrupt was taken.

Top module: `vec_irq_ctrl`

## Requirements
- R1: `mode_o` reports 0 (compatibility) whenever `bev_i`=1, or `iv_i`=0, or `vs_i`=0.
- R2: `mode_o` reports 1 (vectored) when `bev_i`=0, `iv_i`=1, `vs_i` is one of 1, 2, 4, 8 or 16, `vi_cap_i`=1 and `ext_cap_i`=0.
- R3: `mode_o` reports 2 (external controller) when `bev_i`=0, `iv_i`=1, `vs_i` is one of 1, 2, 4, 8 or 16 and `ext_cap_i`=1, whatever `vi_cap_i` is. In this mode `take_o` never asserts.
- R4: `cfg_err_o`=1 and `mode_o`=0 in two cases. The first is `bev_i`=0, `iv_i`=1, `vs_i`=0 with both capability flags at 0. The second is `bev_i`=0, `iv_i`=1 and a nonzero `vs_i` that is not a power of two, with either capability flag at 1. Otherwise `cfg_err_o`=0.
- R5: In compatibility mode the latched offset is 0x180 when `iv_i`=0 and 0x200 when `iv_i`=1.
- R6: In vectored mode the latched offset is 0x200 + vector × (`vs_i` × 32) bytes.
- R7: A request is qualified only if some bit of `pend_o & im_i` is 1, and `ie_i`=1, `exl_i`=0 and `erl_i`=0.
- R8: `vec_o` is the index of the highest set bit of `pend_o & im_i`, scanning from 7 down to 0. Bits 7..2 are hardware lines 5..0 and bits 1..0 are software lines 1..0.
- R9: `pend_o[i]` also takes the timer request when `timer_sel_i`=i, and the performance-counter request when `perf_sel_i`=i, for i in 2..7. Select values 0 and 1 connect the request to no line.
- R10: `pend_o` is combinational and equals {`hw_irq_i`, `sw_irq_i`} OR the merged requests, whatever the mask and enable state.
- R11: `take_o` is registered. It is high for exactly one cycle, in the cycle after the clock edge at which a qualified request is present and the block is not blocked.
- R12: Once `take_o` has fired, no further strobe is produced until `exl_i` has gone from 1 to 0.
- R13: `vec_o` and `offset_o` change only together with `take_o`. A request that is absent or disqualified at the sampling edge latches nothing, and both outputs hold their values. Both are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bev_i | input | 1 | Boot exception vector select |
| iv_i | input | 1 | Interrupt vector select |
| vs_i | input | 5 | Vector spacing code |
| vi_cap_i | input | 1 | Vectored mode capable |
| ext_cap_i | input | 1 | External controller mode capable |
| hw_irq_i | input | 6 | Hardware interrupt lines 5..0 |
| sw_irq_i | input | 2 | Software interrupt lines 1..0 |
| timer_irq_i | input | 1 | Timer request |
| timer_sel_i | input | 3 | Pending bit that receives the timer request |
| perf_irq_i | input | 1 | Performance-counter request |
| perf_sel_i | input | 3 | Pending bit that receives the performance-counter request |
| im_i | input | 8 | Per-line mask |
| ie_i | input | 1 | Global interrupt enable |
| exl_i | input | 1 | Exception level |
| erl_i | input | 1 | Error level |
| pend_o | output | 8 | Current pending lines |
| mode_o | output | 2 | Dispatch mode: 0 compatibility, 1 vectored, 2 external |
| cfg_err_o | output | 1 | Illegal or reserved configuration |
| take_o | output | 1 | Interrupt taken strobe |
| vec_o | output | 3 | Latched vector number |
| offset_o | output | 13 | Latched handler offset from exception base |

## Verification
`pend_o`, `mode_o` and `cfg_err_o` are combinational, so the bench samples them in the same cycle. It drives inputs on the falling edge and reads at the next falling edge. `take_o`, `vec_o` and `offset_o` are due one rising edge after the qualifying input. The bench therefore drops `exl_i` on a falling edge and reads the strobe and latched values on the following falling edge. It reads again one cycle later to confirm the strobe has gone. Blocking, hold and gating cases are read at those same points.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    MODE_COMPAT = 2'd0,
    MODE_VEC    = 2'd1,
    MODE_EXT    = 2'd2
  } irq_mode_e;
endpackage

// File: rtl/irq_mode_decode.sv
module irq_mode_decode
  import irq_pkg::*;
#(
  parameter int VS_W = 5
) (
  input  logic            bev_i,
  input  logic            iv_i,
  input  logic [VS_W-1:0] vs_i,
  input  logic            vi_cap_i,
  input  logic            ext_cap_i,
  output irq_mode_e       mode_o,
  output logic            err_o
);
  logic vs_zero, vs_rsvd, force_compat;

  assign vs_zero      = (vs_i == '0);
  assign vs_rsvd      = !vs_zero && ((vs_i & (vs_i - VS_W'(1))) != '0);
  assign force_compat = bev_i || !iv_i || vs_zero;

  always_comb begin
    mode_o = MODE_COMPAT;
    err_o  = 1'b0;
    if (force_compat) begin
      err_o = !bev_i && iv_i && vs_zero && !vi_cap_i && !ext_cap_i;
    end else if (ext_cap_i) begin
      if (vs_rsvd) err_o = 1'b1;
      else         mode_o = MODE_EXT;
    end else if (vi_cap_i) begin
      if (vs_rsvd) err_o = 1'b1;
      else         mode_o = MODE_VEC;
    end
  end

  always_comb begin
    if (!$isunknown({bev_i, iv_i, vs_i, vi_cap_i, ext_cap_i})) begin
      // R1
      compat_force_chk: assert (!(bev_i || !iv_i || vs_i == '0) || mode_o == MODE_COMPAT);
      // R4
      err_compat_chk: assert (!err_o || mode_o == MODE_COMPAT);
    end
  end
endmodule

// File: rtl/irq_pend_merge.sv
module irq_pend_merge #(
  parameter int NUM_LINES = 8,
  parameter int NUM_SW    = 2,
  parameter int SEL_W     = 3
) (
  input  logic [NUM_LINES-NUM_SW-1:0] hw_i,
  input  logic [NUM_SW-1:0]           sw_i,
  input  logic                        timer_i,
  input  logic [SEL_W-1:0]            timer_sel_i,
  input  logic                        perf_i,
  input  logic [SEL_W-1:0]            perf_sel_i,
  output logic [NUM_LINES-1:0]        pend_o
);
  localparam int NUM_HW = NUM_LINES - NUM_SW;

  assign pend_o[NUM_SW-1:0] = sw_i;

  for (genvar i = NUM_SW; i < NUM_LINES; i++) begin : g_hw
    assign pend_o[i] = hw_i[i-NUM_SW]
                     | (timer_i && (int'(timer_sel_i) == i))
                     | (perf_i  && (int'(perf_sel_i)  == i));
  end

  always_comb begin
    if (!$isunknown({hw_i, pend_o})) begin
      // R10
      hw_pass_chk: assert ((hw_i & ~pend_o[NUM_LINES-1:NUM_SW]) == NUM_HW'(0));
    end
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int NUM_LINES = 8,
  localparam int VEC_W = $clog2(NUM_LINES)
) (
  input  logic [NUM_LINES-1:0] req_i,
  output logic                 valid_o,
  output logic [VEC_W-1:0]     vec_o
);
  always_comb begin
    vec_o = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (req_i[i]) vec_o = VEC_W'(i);
    end
  end

  assign valid_o = |req_i;

  always_comb begin
    if (!$isunknown(req_i) && valid_o) begin
      // R8
      top_bit_chk: assert ((req_i >> vec_o) == NUM_LINES'(1));
    end
  end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int NUM_SW    = 2,
  parameter int SEL_W     = 3,
  parameter int VS_W      = 5,
  parameter int OFF_W     = 13,
  localparam int NUM_HW   = NUM_LINES - NUM_SW,
  localparam int VEC_W    = $clog2(NUM_LINES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bev_i,
  input  logic                 iv_i,
  input  logic [VS_W-1:0]      vs_i,
  input  logic                 vi_cap_i,
  input  logic                 ext_cap_i,
  input  logic [NUM_HW-1:0]    hw_irq_i,
  input  logic [NUM_SW-1:0]    sw_irq_i,
  input  logic                 timer_irq_i,
  input  logic [SEL_W-1:0]     timer_sel_i,
  input  logic                 perf_irq_i,
  input  logic [SEL_W-1:0]     perf_sel_i,
  input  logic [NUM_LINES-1:0] im_i,
  input  logic                 ie_i,
  input  logic                 exl_i,
  input  logic                 erl_i,
  output logic [NUM_LINES-1:0] pend_o,
  output logic [1:0]           mode_o,
  output logic                 cfg_err_o,
  output logic                 take_o,
  output logic [VEC_W-1:0]     vec_o,
  output logic [OFF_W-1:0]     offset_o
);
  localparam logic [OFF_W-1:0] OFF_LEGACY = OFF_W'(12'h180);
  localparam logic [OFF_W-1:0] OFF_IRQ    = OFF_W'(12'h200);
  localparam int               SPC_SHIFT  = 5;

  irq_mode_e              mode;
  logic [NUM_LINES-1:0]   masked;
  logic                   any_req, qual_req;
  logic [VEC_W-1:0]       win_vec;
  logic [OFF_W-1:0]       off_d;
  logic                   exl_q, blocked_q, exl_fall, take_d;

  irq_mode_decode #(.VS_W(VS_W)) i_decode (
    .bev_i     (bev_i),
    .iv_i      (iv_i),
    .vs_i      (vs_i),
    .vi_cap_i  (vi_cap_i),
    .ext_cap_i (ext_cap_i),
    .mode_o    (mode),
    .err_o     (cfg_err_o)
  );

  irq_pend_merge #(.NUM_LINES(NUM_LINES), .NUM_SW(NUM_SW), .SEL_W(SEL_W)) i_merge (
    .hw_i        (hw_irq_i),
    .sw_i        (sw_irq_i),
    .timer_i     (timer_irq_i),
    .timer_sel_i (timer_sel_i),
    .perf_i      (perf_irq_i),
    .perf_sel_i  (perf_sel_i),
    .pend_o      (pend_o)
  );

  assign masked = pend_o & im_i;

  irq_prio_enc #(.NUM_LINES(NUM_LINES)) i_prio (
    .req_i   (masked),
    .valid_o (any_req),
    .vec_o   (win_vec)
  );

  assign mode_o   = mode;
  assign qual_req = any_req && ie_i && !exl_i && !erl_i && (mode != MODE_EXT);

  always_comb begin
    unique case (mode)
      MODE_VEC: off_d = OFF_IRQ + OFF_W'(win_vec) * (OFF_W'(vs_i) << SPC_SHIFT);
      MODE_EXT: off_d = '0;
      default:  off_d = iv_i ? OFF_IRQ : OFF_LEGACY;
    endcase
  end

  // blocking lifts on the cycle exception level falls
  assign exl_fall = exl_q && !exl_i;
  assign take_d   = qual_req && !(blocked_q && !exl_fall);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exl_q     <= 1'b0;
      blocked_q <= 1'b0;
      take_o    <= 1'b0;
      vec_o     <= '0;
      offset_o  <= '0;
    end else begin
      exl_q     <= exl_i;
      blocked_q <= take_d || (blocked_q && !exl_fall);
      take_o    <= take_d;
      if (take_d) begin
        vec_o    <= win_vec;
        offset_o <= off_d;
      end
    end
  end

  // R11
  take_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> !take_o);

  // R7
  take_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(take_o) |-> $past(ie_i && !exl_i && !erl_i && (|(pend_o & im_i))));

  // R3
  ext_no_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(take_o) |-> $past(mode_o != 2'd2));

  // R13
  vec_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_o |-> $stable(vec_o) && $stable(offset_o));
endmodule

// File: tb/test_vec_irq_ctrl.sv
`timescale 1ns/1ps
module test_vec_irq_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bev, iv, vi_cap, ext_cap, timer, perf, ie, exl, erl;
  logic [4:0] vs;
  logic [5:0] hw;
  logic [1:0] sw;
  logic [2:0] timer_sel, perf_sel;
  logic [7:0] im;
  logic [7:0] pend;
  logic [1:0] mode;
  logic cfg_err, take;
  logic [2:0] vec;
  logic [12:0] off;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  vec_irq_ctrl i_vec_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .bev_i(bev), .iv_i(iv), .vs_i(vs),
    .vi_cap_i(vi_cap), .ext_cap_i(ext_cap), .hw_irq_i(hw), .sw_irq_i(sw),
    .timer_irq_i(timer), .timer_sel_i(timer_sel), .perf_irq_i(perf),
    .perf_sel_i(perf_sel), .im_i(im), .ie_i(ie), .exl_i(exl), .erl_i(erl),
    .pend_o(pend), .mode_o(mode), .cfg_err_o(cfg_err), .take_o(take),
    .vec_o(vec), .offset_o(off)
  );

  typedef struct packed {
    logic        bev;
    logic        iv;
    logic [4:0]  vs;
    logic        vi;
    logic        ext;
    logic [5:0]  hw;
    logic [1:0]  sw;
    logic [7:0]  im;
    logic [1:0]  mode;
    logic        err;
    logic        take;
    logic [2:0]  vec;
    logic [12:0] off;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 1'b0, 5'd0,  1'b1, 1'b0, 6'b000000, 2'b10, 8'hFF, 2'd0, 1'b0, 1'b1, 3'd1, 13'h180},
    '{1'b0, 1'b1, 5'd0,  1'b1, 1'b0, 6'b000100, 2'b01, 8'hFF, 2'd0, 1'b0, 1'b1, 3'd4, 13'h200},
    '{1'b1, 1'b1, 5'd1,  1'b1, 1'b0, 6'b100000, 2'b00, 8'hFF, 2'd0, 1'b0, 1'b1, 3'd7, 13'h200},
    '{1'b0, 1'b1, 5'd1,  1'b1, 1'b0, 6'b001001, 2'b00, 8'hFF, 2'd1, 1'b0, 1'b1, 3'd5, 13'h2A0},
    '{1'b0, 1'b1, 5'd4,  1'b1, 1'b0, 6'b000000, 2'b11, 8'hFF, 2'd1, 1'b0, 1'b1, 3'd1, 13'h280},
    '{1'b0, 1'b1, 5'd16, 1'b1, 1'b0, 6'b100000, 2'b00, 8'hFF, 2'd1, 1'b0, 1'b1, 3'd7, 13'h1000},
    '{1'b0, 1'b1, 5'd8,  1'b1, 1'b0, 6'b111111, 2'b00, 8'h3F, 2'd1, 1'b0, 1'b1, 3'd5, 13'h700},
    '{1'b0, 1'b1, 5'd2,  1'b1, 1'b1, 6'b000001, 2'b00, 8'hFF, 2'd2, 1'b0, 1'b0, 3'd0, 13'h0},
    '{1'b0, 1'b1, 5'd0,  1'b0, 1'b0, 6'b000000, 2'b01, 8'hFF, 2'd0, 1'b1, 1'b1, 3'd0, 13'h200},
    '{1'b0, 1'b1, 5'd3,  1'b1, 1'b0, 6'b000010, 2'b00, 8'hFF, 2'd0, 1'b1, 1'b1, 3'd3, 13'h200},
    '{1'b0, 1'b1, 5'd2,  1'b1, 1'b0, 6'b111111, 2'b11, 8'h00, 2'd1, 1'b0, 1'b0, 3'd0, 13'h0},
    '{1'b0, 1'b1, 5'd2,  1'b1, 1'b0, 6'b000000, 2'b00, 8'hFF, 2'd1, 1'b0, 1'b0, 3'd0, 13'h0}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual 0x%0h expected 0x%0h", checks, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bev = 0; iv = 0; vs = 0; vi_cap = 0; ext_cap = 0; hw = 0; sw = 0;
    timer = 0; perf = 0; timer_sel = 0; perf_sel = 0; im = 0;
    ie = 1; exl = 0; erl = 0;
    @(negedge clk); @(negedge clk);
    // R13 reset state
    chk(take == 1'b0, "R13 reset take", int'(take), 0);
    chk(vec == 3'd0, "R13 reset vec", int'(vec), 0);
    chk(off == 13'd0, "R13 reset offset", int'(off), 0);
    chk(mode == 2'd0, "R1 reset mode", int'(mode), 0);
    rst_n = 1'b1;
    tick();
    chk(take == 1'b0, "R7 idle no take", int'(take), 0);

    // table walk: R1 R2 R3 R4 R5 R6 R8 R10 R11
    for (int k = 0; k < NV; k++) begin
      exl = 1; bev = TBL[k].bev; iv = TBL[k].iv; vs = TBL[k].vs;
      vi_cap = TBL[k].vi; ext_cap = TBL[k].ext; hw = TBL[k].hw;
      sw = TBL[k].sw; im = TBL[k].im;
      tick();
      chk(mode == TBL[k].mode, $sformatf("R1/R2/R3 mode row %0d", k), int'(mode), int'(TBL[k].mode));
      chk(cfg_err == TBL[k].err, $sformatf("R4 err row %0d", k), int'(cfg_err), int'(TBL[k].err));
      chk(pend == {TBL[k].hw, TBL[k].sw}, $sformatf("R10 pend row %0d", k), int'(pend), int'({TBL[k].hw, TBL[k].sw}));
      chk(take == 1'b0, $sformatf("R7 exl gate row %0d", k), int'(take), 0);
      exl = 0;
      tick();
      chk(take == TBL[k].take, $sformatf("R11 take row %0d", k), int'(take), int'(TBL[k].take));
      if (TBL[k].take) begin
        chk(vec == TBL[k].vec, $sformatf("R8 vec row %0d", k), int'(vec), int'(TBL[k].vec));
        chk(off == TBL[k].off, $sformatf("R5/R6 offset row %0d", k), int'(off), int'(TBL[k].off));
      end
      tick();
      chk(take == 1'b0, $sformatf("R11 single pulse row %0d", k), int'(take), 0);
    end

    // R9 timer onto line 7, perf on select 1 goes nowhere
    exl = 1; bev = 0; iv = 1; vs = 5'd1; vi_cap = 1; ext_cap = 0;
    hw = 0; sw = 0; im = 8'hFF; timer = 1; timer_sel = 3'd7; perf = 1; perf_sel = 3'd1;
    tick();
    chk(pend == 8'h80, "R9 timer merge, perf sel 1 ignored", int'(pend), 'h80);
    exl = 0;
    tick();
    chk(take == 1'b1, "R9 timer take", int'(take), 1);
    chk(vec == 3'd7, "R9 timer vec", int'(vec), 7);
    chk(off == 13'h2E0, "R6 timer offset", int'(off), 'h2E0);

    // R12 no retake while blocked, R13 hold
    timer = 0; perf_sel = 3'd3;
    tick();
    chk(pend == 8'h08, "R9 perf merge line 3", int'(pend), 'h08);
    chk(take == 1'b0, "R12 blocked new request", int'(take), 0);
    tick();
    chk(take == 1'b0, "R12 still blocked", int'(take), 0);
    chk(vec == 3'd7, "R13 vec held", int'(vec), 7);
    chk(off == 13'h2E0, "R13 offset held", int'(off), 'h2E0);

    // R7 global enable off
    ie = 0; exl = 1;
    tick();
    exl = 0;
    tick();
    chk(take == 1'b0, "R7 ie low no take", int'(take), 0);
    chk(vec == 3'd7, "R13 vec held ie low", int'(vec), 7);
    ie = 1;
    tick();
    chk(take == 1'b1, "R7 ie restored take", int'(take), 1);
    chk(vec == 3'd3, "R9 perf vec", int'(vec), 3);
    chk(off == 13'h260, "R6 perf offset", int'(off), 'h260);

    // R7 error level
    erl = 1; exl = 1;
    tick();
    exl = 0;
    tick();
    chk(take == 1'b0, "R7 erl high no take", int'(take), 0);
    chk(vec == 3'd3, "R13 vec held erl", int'(vec), 3);

    // R10 pending visible with mask clear
    im = 8'h00; perf = 0; hw = 6'b010101; sw = 2'b10;
    tick();
    chk(pend == 8'h56, "R10 pend masked out", int'(pend), 'h56);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule